// File: doc/BRIEF.md
# Parallel Camera Capture Front-End

This block sits between a parallel camera port and a receive FIFO. It works in a single system clock domain. The pixel clock, enable, line sync and frame sync lines are sampled as ordinary inputs. An active pixel-clock edge is found by edge detection after optional polarity inversion. The frame sync is debounced by a glitch filter with a programmable threshold. Pixels are then qualified, either by enable, line sync and frame sync together, or by enable and frame sync alone. Qualified samples are packed into 16-bit words. In narrow mode, two consecutive 8-bit samples form one word, with the first sample in the low byte.

Each word can have its two bytes swapped and the bits inside each byte mirrored before it leaves the block. The end of a frame is flagged in one of two ways: on the falling edge of the filtered frame sync, or when a programmed byte total has been taken in. A line counter raises a periodic interrupt. Capture can pause while the downstream FIFO is full.

Settings take effect only on an update pulse, which also latches the start bit. A soft reset pulse clears the capture state and the interrupt status. Two interrupt status bits have enable and write-one-to-clear controls.

Top module: `cam_capture`

## Requirements
- R1: After rst_ni is low, pix_valid_o, eof_o, irq_o and int_st_o are all zero.
- R2: The setting ports and start_i have no effect until update_i is pulsed. While the latched start bit is 0, no word is produced.
- R3: With wide_i latched at 1, each active pixel-clock edge that sees the filtered frame sync, the line sync and the enable all high produces one word, data_i[15:0], on pix_valid_o/pix_data_o.
- R4: With wide_i latched at 0, only data_i[7:0] is used. Two qualified samples form one word, with the first sample in bits 7:0 and the second in bits 15:8.
- R5: inv_pclk_i, inv_de_i, inv_hs_i and inv_vs_i each invert their line independently. With inv_pclk_i set, the falling edge of pclk_i is the active edge.
- R6: With vs_filt_en_i set, the filtered frame sync takes a new level only on the (thr+1)-th consecutive active edge that sees that level. Shorter pulses are ignored. With the filter off, the new level is taken on the first edge. A sample is qualified against the filtered level held before that edge.
- R7: With sync3_mode_i at 0, hs_i is ignored and the line sync is taken to be equal to the enable. With sync3_mode_i at 1, a low hs_i blocks capture.
- R8: With vs_eof_en_i set, eof_o pulses once on each falling edge of the filtered frame sync, and status bit 2 is set.
- R9: With vs_eof_en_i clear, eof_o pulses together with the word that brings the frame's byte total (2 per word) to at least rec_len_i. Any further words in that frame are dropped. A new frame (rising edge of the filtered frame sync) clears the count.
- R10: Each falling edge of the line sync inside a frame counts one line. When the count reaches line_num_i (nonzero), status bit 3 is set and the count restarts from 0. A value of 0 never fires. The count clears at each frame start.
- R11: With stop_en_i set, no sample is taken while fifo_full_i is high. With stop_en_i clear, fifo_full_i is ignored.
- R12: byte_swap_i exchanges the two bytes of each word. bit_rev_i then mirrors the bit order inside each byte.
- R13: Only status bits 2 (end of frame) and 3 (line) exist, and bits 1:0 always read 0. Writing 1 on a bit of int_clr_i clears that status bit. irq_o is high when any status bit in 3:2 is set and its int_ena_i bit is 1.
- R14: A soft_rst_i pulse clears the status bits, the filter, the byte and line counters and the narrow-mode pairing. The latched settings are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| update_i | input | 1 | Pulse that latches all setting ports and start_i |
| soft_rst_i | input | 1 | Pulse that clears capture state and status |
| start_i | input | 1 | Capture run bit, latched on update |
| inv_pclk_i | input | 1 | Invert pixel clock |
| inv_de_i | input | 1 | Invert data enable |
| inv_hs_i | input | 1 | Invert line sync |
| inv_vs_i | input | 1 | Invert frame sync |
| vs_filt_en_i | input | 1 | Enable frame sync glitch filter |
| vs_filt_thr_i | input | 3 | Filter threshold, 0 to 7 |
| sync3_mode_i | input | 1 | 1: enable, line and frame sync qualify; 0: line sync follows the enable |
| wide_i | input | 1 | 1: 16-bit samples; 0: 8-bit samples paired into words |
| vs_eof_en_i | input | 1 | 1: end of frame from frame sync; 0: from byte total |
| rec_len_i | input | 16 | Byte total per frame for count-based end of frame |
| line_num_i | input | 6 | Lines per line interrupt |
| stop_en_i | input | 1 | Pause capture while the FIFO is full |
| byte_swap_i | input | 1 | Swap the two bytes of each word |
| bit_rev_i | input | 1 | Mirror the bits inside each byte |
| int_ena_i | input | 4 | Interrupt enables, bits 3:2 used |
| int_clr_i | input | 4 | Write-one-to-clear status, bits 3:2 used |
| pclk_i | input | 1 | Camera pixel clock, sampled |
| de_i | input | 1 | Camera data enable |
| hs_i | input | 1 | Camera line sync |
| vs_i | input | 1 | Camera frame sync |
| data_i | input | 16 | Camera data bus |
| fifo_full_i | input | 1 | Downstream receive FIFO full |
| pix_valid_o | output | 1 | Word valid, one cycle |
| pix_data_o | output | 16 | Packed, reordered word |
| eof_o | output | 1 | End-of-frame pulse |
| int_st_o | output | 4 | Interrupt status, bit 2 end of frame, bit 3 line |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench walks a table of samples through every combination of wide or narrow packing, byte swap and bit mirroring. Each combination has an asymmetric pattern, so a swapped, unmirrored or wrongly paired word shows a distinct value. Frames with short frame-sync glitches, tried with the filter on and off, separate filtered from raw sync. A frame whose first data beat arrives on the edge that raises the filtered sync confirms that the pre-edge level is used for qualification.

Frames are sent with the line sync held low, in both sync modes, and with every line inverted. Other frames run past the programmed byte total, sit under a full FIFO, or span four lines. Each of these separates one control path: mode selection, polarity, count-based end of frame with drop, stall gating, and line-counter restart.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int DW      = 16;
  localparam int BW      = 8;
  localparam int NB      = DW / BW;
  localparam int THR_W   = 3;
  localparam int LEN_W   = 16;
  localparam int LINE_W  = 6;
  localparam int INT_W   = 4;
  localparam int INT_EOF = 2;
  localparam int INT_LN  = 3;

  typedef struct packed {
    logic              start;
    logic              inv_pclk;
    logic              inv_de;
    logic              inv_hs;
    logic              inv_vs;
    logic              filt_en;
    logic [THR_W-1:0]  filt_thr;
    logic              sync3;
    logic              wide;
    logic              vs_eof;
    logic              stop_en;
    logic              byte_swap;
    logic              bit_rev;
    logic [LEN_W-1:0]  rec_len;
    logic [LINE_W-1:0] line_num;
  } cam_cfg_t;
endpackage

// File: rtl/cam_sync_cond.sv
module cam_sync_cond
  import cam_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  cam_cfg_t      cfg_i,
  input  logic          pclk_i,
  input  logic          de_i,
  input  logic          hs_i,
  input  logic          vs_i,
  input  logic [DW-1:0] data_i,
  output logic          tick_o,
  output logic          vs_o,
  output logic          hs_o,
  output logic          de_o,
  output logic [DW-1:0] data_o,
  output logic          vs_rise_o,
  output logic          vs_fall_o
);
  logic             pclk_q, pclk_p, de_q, hs_q, vs_q, vs_f, rise_q, fall_q;
  logic [DW-1:0]    data_q;
  logic [THR_W-1:0] cnt_q, thr;

  assign thr    = cfg_i.filt_en ? cfg_i.filt_thr : '0;
  assign tick_o = pclk_q & ~pclk_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {pclk_q, pclk_p, de_q, hs_q, vs_q, vs_f, rise_q, fall_q} <= '0;
      data_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      {pclk_q, pclk_p, de_q, hs_q, vs_q, vs_f, rise_q, fall_q} <= '0;
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      pclk_q <= pclk_i ^ cfg_i.inv_pclk;
      pclk_p <= pclk_q;
      de_q   <= de_i ^ cfg_i.inv_de;
      hs_q   <= hs_i ^ cfg_i.inv_hs;
      vs_q   <= vs_i ^ cfg_i.inv_vs;
      data_q <= data_i;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (tick_o) begin
        if (vs_q == vs_f) cnt_q <= '0;
        else if (cnt_q >= thr) begin
          vs_f   <= vs_q;
          cnt_q  <= '0;
          rise_q <= vs_q;
          fall_q <= ~vs_q;
        end else cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign vs_o      = vs_f;
  assign hs_o      = cfg_i.sync3 ? hs_q : de_q;
  assign de_o      = de_q;
  assign data_o    = data_q;
  assign vs_rise_o = rise_q;
  assign vs_fall_o = fall_q;

  // R6: filtered sync moves only on an active edge
  a_r6_vs_moves_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && !clr_i) |=> $stable(vs_f));
  a_r6_edge_pulses_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_q && fall_q));
endmodule

// File: rtl/cam_pack.sv
module cam_pack
  import cam_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  cam_cfg_t      cfg_i,
  input  logic          tick_i,
  input  logic          vs_i,
  input  logic          hs_i,
  input  logic          de_i,
  input  logic [DW-1:0] data_i,
  input  logic          frame_start_i,
  input  logic          fifo_full_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          cnt_eof_o
);
  logic            accept, word_rdy, phase_q, done_q;
  logic [BW-1:0]   lo_q;
  logic [DW-1:0]   word_raw, word_swp, word_out;
  logic [LEN_W-1:0] bytes_q;
  logic [LEN_W:0]  bytes_sum;

  assign accept = tick_i & cfg_i.start & vs_i & hs_i & de_i & ~done_q
                & ~(cfg_i.stop_en & fifo_full_i);
  assign word_rdy  = accept & (cfg_i.wide | phase_q);
  assign word_raw  = cfg_i.wide ? data_i : {data_i[BW-1:0], lo_q};
  assign bytes_sum = {1'b0, bytes_q} + (LEN_W+1)'(NB);

  always_comb begin
    word_swp = word_raw;
    if (cfg_i.byte_swap)
      for (int b = 0; b < NB; b++) word_swp[b*BW +: BW] = word_raw[(NB-1-b)*BW +: BW];
    word_out = word_swp;
    if (cfg_i.bit_rev)
      for (int b = 0; b < NB; b++)
        for (int i = 0; i < BW; i++) word_out[b*BW+i] = word_swp[b*BW+BW-1-i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {valid_o, cnt_eof_o, phase_q, done_q} <= '0;
      lo_q <= '0; data_o <= '0; bytes_q <= '0;
    end else if (clr_i) begin
      {valid_o, cnt_eof_o, phase_q, done_q} <= '0;
      lo_q <= '0; data_o <= '0; bytes_q <= '0;
    end else begin
      valid_o   <= 1'b0;
      cnt_eof_o <= 1'b0;
      if (frame_start_i) begin
        bytes_q <= '0;
        phase_q <= 1'b0;
        done_q  <= 1'b0;
      end else if (accept) begin
        if (!cfg_i.wide) begin
          phase_q <= ~phase_q;
          if (!phase_q) lo_q <= data_i[BW-1:0];
        end
        if (word_rdy) begin
          valid_o <= 1'b1;
          data_o  <= word_out;
          bytes_q <= bytes_sum[LEN_W-1:0];
          if (!cfg_i.vs_eof && bytes_sum >= {1'b0, cfg_i.rec_len}) begin
            cnt_eof_o <= 1'b1;
            done_q    <= 1'b1;
          end
        end
      end
    end
  end

  // R11: a full FIFO with stop enabled yields no word
  a_r11_stall_on_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cfg_i.stop_en && fifo_full_i) |=> !valid_o);
  // R3: words only follow an active pixel edge
  a_r3_word_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(tick_i));
endmodule

// File: rtl/cam_irq.sv
module cam_irq
  import cam_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  cam_cfg_t         cfg_i,
  input  logic             tick_i,
  input  logic             vs_i,
  input  logic             hs_i,
  input  logic             frame_start_i,
  input  logic             eof_i,
  input  logic [INT_W-1:0] ena_i,
  input  logic [INT_W-1:0] wclr_i,
  output logic [INT_W-1:0] st_o,
  output logic             irq_o
);
  localparam logic [INT_W-1:0] MASK = (INT_W'(1) << INT_EOF) | (INT_W'(1) << INT_LN);

  logic              hs_p, line_end, line_evt;
  logic [LINE_W-1:0] cnt_q;
  logic [INT_W-1:0]  st_q, set_v, st_nxt;

  assign line_end = tick_i & cfg_i.start & vs_i & hs_p & ~hs_i;
  assign line_evt = line_end & (cfg_i.line_num != '0) & (cnt_q + 1'b1 == cfg_i.line_num);

  always_comb begin
    set_v = '0;
    set_v[INT_EOF] = eof_i;
    set_v[INT_LN]  = line_evt;
    st_nxt = (set_v | (st_q & ~wclr_i)) & MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_p <= 1'b0; cnt_q <= '0; st_q <= '0;
    end else if (clr_i) begin
      hs_p <= 1'b0; cnt_q <= '0; st_q <= '0;
    end else begin
      st_q <= st_nxt;
      if (tick_i) hs_p <= hs_i;
      if (frame_start_i) cnt_q <= '0;
      else if (line_evt) cnt_q <= '0;
      else if (line_end) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign st_o  = st_q;
  assign irq_o = |(st_q & ena_i & MASK);

  // R10: line status can only rise inside a frame
  a_r10_line_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q[INT_LN]) |-> $past(vs_i));
  // R13: write-one clears end-of-frame status
  a_r13_clear_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wclr_i[INT_EOF] && !eof_i) |=> !st_q[INT_EOF]);
endmodule

// File: rtl/cam_capture.sv
module cam_capture
  import cam_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              update_i,
  input  logic              soft_rst_i,
  input  logic              start_i,
  input  logic              inv_pclk_i,
  input  logic              inv_de_i,
  input  logic              inv_hs_i,
  input  logic              inv_vs_i,
  input  logic              vs_filt_en_i,
  input  logic [THR_W-1:0]  vs_filt_thr_i,
  input  logic              sync3_mode_i,
  input  logic              wide_i,
  input  logic              vs_eof_en_i,
  input  logic [LEN_W-1:0]  rec_len_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              stop_en_i,
  input  logic              byte_swap_i,
  input  logic              bit_rev_i,
  input  logic [INT_W-1:0]  int_ena_i,
  input  logic [INT_W-1:0]  int_clr_i,
  input  logic              pclk_i,
  input  logic              de_i,
  input  logic              hs_i,
  input  logic              vs_i,
  input  logic [DW-1:0]     data_i,
  input  logic              fifo_full_i,
  output logic              pix_valid_o,
  output logic [DW-1:0]     pix_data_o,
  output logic              eof_o,
  output logic [INT_W-1:0]  int_st_o,
  output logic              irq_o
);
  cam_cfg_t      cfg_q, cfg_d;
  logic          tick, vs_f, hs_e, de_e, vs_rise, vs_fall, cnt_eof;
  logic [DW-1:0] data_q;

  always_comb begin
    cfg_d.start     = start_i;
    cfg_d.inv_pclk  = inv_pclk_i;
    cfg_d.inv_de    = inv_de_i;
    cfg_d.inv_hs    = inv_hs_i;
    cfg_d.inv_vs    = inv_vs_i;
    cfg_d.filt_en   = vs_filt_en_i;
    cfg_d.filt_thr  = vs_filt_thr_i;
    cfg_d.sync3     = sync3_mode_i;
    cfg_d.wide      = wide_i;
    cfg_d.vs_eof    = vs_eof_en_i;
    cfg_d.stop_en   = stop_en_i;
    cfg_d.byte_swap = byte_swap_i;
    cfg_d.bit_rev   = bit_rev_i;
    cfg_d.rec_len   = rec_len_i;
    cfg_d.line_num  = line_num_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (update_i) cfg_q <= cfg_d;
  end

  cam_sync_cond u_cond (
    .clk_i, .rst_ni, .clr_i(soft_rst_i), .cfg_i(cfg_q),
    .pclk_i, .de_i, .hs_i, .vs_i, .data_i,
    .tick_o(tick), .vs_o(vs_f), .hs_o(hs_e), .de_o(de_e), .data_o(data_q),
    .vs_rise_o(vs_rise), .vs_fall_o(vs_fall)
  );

  cam_pack u_pack (
    .clk_i, .rst_ni, .clr_i(soft_rst_i), .cfg_i(cfg_q),
    .tick_i(tick), .vs_i(vs_f), .hs_i(hs_e), .de_i(de_e), .data_i(data_q),
    .frame_start_i(vs_rise), .fifo_full_i,
    .valid_o(pix_valid_o), .data_o(pix_data_o), .cnt_eof_o(cnt_eof)
  );

  assign eof_o = (cfg_q.vs_eof & cfg_q.start & vs_fall) | cnt_eof;

  cam_irq u_irq (
    .clk_i, .rst_ni, .clr_i(soft_rst_i), .cfg_i(cfg_q),
    .tick_i(tick), .vs_i(vs_f), .hs_i(hs_e), .frame_start_i(vs_rise),
    .eof_i(eof_o), .ena_i(int_ena_i), .wclr_i(int_clr_i),
    .st_o(int_st_o), .irq_o
  );

  // R8: end of frame is a single-cycle pulse
  a_r8_eof_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !eof_o);
  // R2: no word while the latched start bit is clear
  a_r2_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q.start |=> !pix_valid_o);
endmodule

// File: tb/cam_capture_test.sv
`timescale 1ns/1ps
module cam_capture_test;
  logic clk = 0, rst_ni = 0, update_i = 0, soft_rst_i = 0, start_i = 0;
  logic inv_pclk_i = 0, inv_de_i = 0, inv_hs_i = 0, inv_vs_i = 0;
  logic vs_filt_en_i = 0, sync3_mode_i = 1, wide_i = 1, vs_eof_en_i = 1;
  logic [2:0] vs_filt_thr_i = 0;
  logic [15:0] rec_len_i = 0;
  logic [5:0] line_num_i = 0;
  logic stop_en_i = 0, byte_swap_i = 0, bit_rev_i = 0, fifo_full_i = 0;
  logic [3:0] int_ena_i = 0, int_clr_i = 0;
  logic pclk_i = 0, de_i = 0, hs_i = 0, vs_i = 0;
  logic [15:0] data_i = 0;
  logic pix_valid_o, eof_o, irq_o;
  logic [15:0] pix_data_o;
  logic [3:0] int_st_o;

  int nchk = 0, nfail = 0, nw = 0, neof = 0, eof_at = 0;
  logic [15:0] words [64];
  logic ended = 0;

  always #2.5 clk = ~clk;

  cam_capture uut (.*, .clk_i(clk));

  always @(negedge clk) begin
    if (pix_valid_o && nw < 64) begin words[nw] = pix_data_o; nw++; end
    if (eof_o) begin neof++; eof_at = nw; end
  end

  // {wide, swap, rev, d0, d1, expected}
  localparam logic [50:0] VEC [8] = '{
    {3'b100, 16'hA1B2, 16'h0000, 16'hA1B2},
    {3'b110, 16'hA1B2, 16'h0000, 16'hB2A1},
    {3'b101, 16'h8001, 16'h0000, 16'h0180},
    {3'b111, 16'h1234, 16'h0000, 16'h2C48},
    {3'b000, 16'hFF55, 16'hEEAA, 16'hAA55},
    {3'b010, 16'h0011, 16'h0022, 16'h1122},
    {3'b001, 16'h0001, 16'h0080, 16'h0180},
    {3'b011, 16'h0012, 16'h0034, 16'h482C}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat(logic de, logic hs, logic vs, logic [15:0] d);
    @(negedge clk);
    de_i = de ^ inv_de_i; hs_i = hs ^ inv_hs_i; vs_i = vs ^ inv_vs_i;
    data_i = d; pclk_i = inv_pclk_i;
    repeat (2) @(negedge clk);
    pclk_i = ~inv_pclk_i;
    repeat (2) @(negedge clk);
    pclk_i = inv_pclk_i;
  endtask

  task automatic clear_mon();
    @(posedge clk);
    nw = 0; neof = 0; eof_at = 0;
  endtask

  task automatic pulse_update();
    @(negedge clk); update_i = 1;
    @(negedge clk); update_i = 0;
  endtask

  task automatic reconfig();
    pulse_update();
    beat(0, 0, 0, 0); beat(0, 0, 0, 0);
    @(negedge clk); soft_rst_i = 1;
    @(negedge clk); soft_rst_i = 0;
    clear_mon();
  endtask

  task automatic frame2(logic [15:0] a, logic [15:0] b);
    beat(0, 0, 1, 0);
    beat(1, 1, 1, a);
    beat(1, 1, 1, b);
    beat(0, 0, 0, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic line(logic [15:0] a);
    beat(1, 1, 1, a); beat(1, 1, 1, a + 1); beat(0, 0, 1, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 valid", pix_valid_o, 0);
    check("R1 eof", eof_o, 0);
    check("R1 status", int_st_o, 0);
    check("R1 irq", irq_o, 0);
    rst_ni = 1;

    // R2: start without update has no effect
    start_i = 1;
    frame2(16'h1234, 16'h5678);
    check("R2 no words before update", nw, 0);
    reconfig();
    frame2(16'h1234, 16'h5678);
    check("R3 word count", nw, 2);
    check("R3 first word", words[0], 16'h1234);
    check("R3 second word", words[1], 16'h5678);

    // R12/R3/R4 table walk
    foreach (VEC[k]) begin
      wide_i = VEC[k][50]; byte_swap_i = VEC[k][49]; bit_rev_i = VEC[k][48];
      reconfig();
      beat(0, 0, 1, 0);
      beat(1, 1, 1, VEC[k][47:32]);
      if (!VEC[k][50]) beat(1, 1, 1, VEC[k][31:16]);
      beat(0, 0, 0, 0);
      repeat (4) @(negedge clk);
      check($sformatf("R12 R4 vec%0d count", k), nw, 1);
      check($sformatf("R12 R4 vec%0d word", k), words[0], VEC[k][15:0]);
    end
    wide_i = 1; byte_swap_i = 0; bit_rev_i = 0;

    // R8 and R13
    int_ena_i = 4'h4;
    reconfig();
    frame2(16'h0101, 16'h0202);
    check("R8 one eof", neof, 1);
    check("R8 eof after last word", eof_at, 2);
    check("R8 status bit2", int_st_o, 4'h4);
    check("R13 irq enabled", irq_o, 1);
    int_ena_i = 4'h3;
    @(negedge clk);
    check("R13 low enables ignored", irq_o, 0);
    int_clr_i = 4'h4; @(negedge clk); int_clr_i = 0; @(negedge clk);
    check("R13 cleared", int_st_o, 0);

    // R14: soft reset clears status
    frame2(16'h0, 16'h0);
    check("R14 status set before", int_st_o[2], 1);
    @(negedge clk); soft_rst_i = 1; @(negedge clk); soft_rst_i = 0; @(negedge clk);
    check("R14 status cleared", int_st_o, 0);

    // R9: byte-count end of frame
    vs_eof_en_i = 0; rec_len_i = 6;
    reconfig();
    beat(0, 0, 1, 0);
    for (int i = 0; i < 5; i++) beat(1, 1, 1, 16'h10 + i);
    beat(0, 0, 0, 0); repeat (4) @(negedge clk);
    check("R9 words kept", nw, 3);
    check("R9 single eof", neof, 1);
    check("R9 eof on third word", eof_at, 3);
    check("R9 last word", words[2], 16'h0012);
    frame2(16'hAAAA, 16'hBBBB);
    check("R9 next frame restarts", nw, 5);
    vs_eof_en_i = 1;

    // R5: all lines inverted
    inv_pclk_i = 1; inv_de_i = 1; inv_hs_i = 1; inv_vs_i = 1;
    reconfig();
    frame2(16'hC0DE, 16'hBEEF);
    check("R5 inverted count", nw, 2);
    check("R5 inverted word", words[1], 16'hBEEF);
    inv_pclk_i = 0; inv_de_i = 0; inv_hs_i = 0; inv_vs_i = 0;

    // R6: filter on, threshold 3
    vs_filt_en_i = 1; vs_filt_thr_i = 3;
    reconfig();
    beat(0, 0, 1, 0); beat(0, 0, 1, 0); beat(0, 0, 1, 0);
    beat(1, 1, 1, 16'hDEAD);
    beat(1, 1, 1, 16'h0A0A);
    beat(0, 0, 0, 0); beat(0, 0, 0, 0);
    beat(0, 0, 1, 0);
    beat(1, 1, 1, 16'h0B0B);
    repeat (3) @(negedge clk);
    check("R6 glitch ignored", neof, 0);
    for (int i = 0; i < 5; i++) beat(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R6 filtered count", nw, 2);
    check("R6 edge-raising beat dropped", words[0], 16'h0A0A);
    check("R6 data after glitch", words[1], 16'h0B0B);
    check("R6 final eof", neof, 1);
    vs_filt_en_i = 0;
    reconfig();
    beat(0, 0, 1, 0); beat(1, 1, 1, 16'h1111);
    beat(0, 0, 0, 0); beat(0, 0, 1, 0); beat(1, 1, 1, 16'h2222);
    repeat (3) @(negedge clk);
    check("R6 bypass sees glitch", neof, 1);
    check("R6 bypass words", nw, 2);
    beat(0, 0, 0, 0);
    vs_filt_thr_i = 0;

    // R7: two sync modes with line sync held low
    sync3_mode_i = 0;
    reconfig();
    beat(0, 0, 1, 0); beat(1, 0, 1, 16'h7777); beat(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R7 hs ignored", nw, 1);
    sync3_mode_i = 1;
    reconfig();
    beat(0, 0, 1, 0); beat(1, 0, 1, 16'h7777); beat(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R7 hs low blocks", nw, 0);

    // R10: line interrupt every 2 lines
    line_num_i = 2;
    reconfig();
    beat(0, 0, 1, 0);
    line(16'h100);
    check("R10 after one line", int_st_o[3], 0);
    line(16'h200);
    check("R10 after two lines", int_st_o[3], 1);
    int_clr_i = 4'h8; @(negedge clk); int_clr_i = 0;
    line(16'h300);
    check("R10 restart after fire", int_st_o[3], 0);
    line(16'h400);
    check("R10 fires again", int_st_o[3], 1);
    beat(0, 0, 0, 0);
    line_num_i = 0;

    // R11: stop on full
    stop_en_i = 1; fifo_full_i = 1;
    reconfig();
    beat(0, 0, 1, 0); beat(1, 1, 1, 16'h1); beat(1, 1, 1, 16'h2);
    repeat (3) @(negedge clk);
    check("R11 paused while full", nw, 0);
    fifo_full_i = 0;
    beat(1, 1, 1, 16'h3); beat(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R11 resumes", nw, 1);
    stop_en_i = 0; fifo_full_i = 1;
    reconfig();
    frame2(16'h4, 16'h5);
    check("R11 full ignored when disabled", nw, 2);
    fifo_full_i = 0;

    ended = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule